// File: doc/BRIEF.md
# Region Permission Evaluation Slice

This block judges one bus access against one region descriptor of a memory protection unit. It takes the access attributes: the address, whether the access is an instruction fetch or a data access, and for data accesses whether it is a read or a write. It also takes the region's lower and upper address bounds, its valid flag and its three effective permission bits (read, write, execute). From these it forms four outputs:

- an active-low hit flag;
- a permission-violation flag;
- a combined "this region does not allow the access" term;
- an enable that tells error-detail logic to record this region's violation.

All outputs are combinational. The block holds no state, so there is no valid/ready handshake: the outputs follow the inputs in the same cycle. Back-pressure does not apply. Many slices sit side by side in a protection unit. A parent reduces the combined deny terms of all slices with an AND to reach one bus decision. Each slice's capture enable still marks which hit regions refused the access.

Top module: `rgn_perm_slice`

## Requirements
- R1: With the valid flag at 1 and `rgn_lo <= acc_addr <= rgn_hi` (unsigned, full `ADDR_W` width), `hit_n` is 0. Any address outside that window gives `hit_n` = 1.
- R2: Both bounds are inclusive. An address equal to `rgn_lo` or to `rgn_hi` hits. `rgn_lo - 1` and `rgn_hi + 1` miss.
- R3: With the valid flag at 0, `hit_n` is 1 and `err_capture` is 0 for every address and permission setting.
- R4: For an instruction fetch (`acc_fetch` = 1), `viol` equals the inverse of `perm_x`.
- R5: For a data read (`acc_fetch` = 0, `acc_write` = 0), `viol` equals the inverse of `perm_r`.
- R6: For a data write (`acc_fetch` = 0, `acc_write` = 1), `viol` equals the inverse of `perm_w`.
- R7: The two permission bits that do not match the access type have no effect on `viol`.
- R8: When `acc_fetch` is 1, the value of `acc_write` has no effect on `viol`.
- R9: `deny` is 1 exactly when `hit_n` is 1 or `viol` is 1.
- R10: `err_capture` is 1 exactly when `hit_n` is 0 and `viol` is 1.
- R11: `viol` does not depend on the address window or the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | ADDR_W | Address of the access |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_write | input | 1 | For data accesses: 1 = write, 0 = read |
| rgn_lo | input | ADDR_W | Lowest address of the region, inclusive |
| rgn_hi | input | ADDR_W | Highest address of the region, inclusive |
| rgn_valid | input | 1 | Descriptor valid flag |
| perm_r | input | 1 | Effective read permission |
| perm_w | input | 1 | Effective write permission |
| perm_x | input | 1 | Effective execute permission |
| hit_n | output | 1 | Active-low region hit |
| viol | output | 1 | Permission violation for this access type |
| deny | output | 1 | Region does not allow this access |
| err_capture | output | 1 | Region hit and violated: record details |

## Verification
The bench sweeps addresses one below the lower bound, on each bound, in the middle of the window and one above the upper bound. A comparator with an off-by-one or a strict inequality would then miss a bound or grant a neighbour. Every access kind is paired with all eight permission patterns. A slice that consulted the wrong permission bit, or let a don't-care bit leak into its decision, would flag allowed accesses or pass forbidden ones. Fetches are driven with both write-flag values, which exposes decoding that lets a fetch fall into the write check. Invalid descriptors and full-range windows check that an unprogrammed region never grants access or requests capture, and that the end bounds of the address space still hit.

// File: rtl/rgn_perm_pkg.sv
package rgn_perm_pkg;
  typedef enum logic [1:0] {
    ACC_DREAD  = 2'b00,
    ACC_DWRITE = 2'b01,
    ACC_IFETCH = 2'b10
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic fetch, input logic write);
    if (fetch)      return ACC_IFETCH;
    else if (write) return ACC_DWRITE;
    else            return ACC_DREAD;
  endfunction
endpackage

// File: rtl/rgn_window_cmp.sv
module rgn_window_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              valid,
  output logic              hit_n
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    hit_n    = ~(valid & above_lo & below_hi);
  end

  always_comb begin
    // R3
    invalid_never_hits_chk: assert (valid || hit_n);
    // R2
    lo_bound_hits_chk: assert (!(valid && addr == lo && lo <= hi) || !hit_n);
  end
endmodule

// File: rtl/rgn_perm_check.sv
module rgn_perm_check
  import rgn_perm_pkg::*;
(
  input  logic fetch,
  input  logic write,
  input  logic pr,
  input  logic pw,
  input  logic px,
  output logic viol
);
  acc_kind_e kind;

  always_comb begin
    kind = classify(fetch, write);
    unique case (kind)
      ACC_IFETCH: viol = ~px;
      ACC_DWRITE: viol = ~pw;
      default:    viol = ~pr;
    endcase
  end

  always_comb begin
    // R8
    fetch_ignores_write_chk: assert (!fetch || (viol == ~px));
    // R7
    all_granted_no_viol_chk: assert (!(pr && pw && px) || !viol);
  end
endmodule

// File: rtl/rgn_perm_slice.sv
module rgn_perm_slice #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_fetch,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] rgn_lo,
  input  logic [ADDR_W-1:0] rgn_hi,
  input  logic              rgn_valid,
  input  logic              perm_r,
  input  logic              perm_w,
  input  logic              perm_x,
  output logic              hit_n,
  output logic              viol,
  output logic              deny,
  output logic              err_capture
);
  logic win_hit_n;
  logic perm_viol;

  rgn_window_cmp #(.ADDR_W(ADDR_W)) u_win (
    .addr  (acc_addr),
    .lo    (rgn_lo),
    .hi    (rgn_hi),
    .valid (rgn_valid),
    .hit_n (win_hit_n)
  );

  rgn_perm_check u_perm (
    .fetch (acc_fetch),
    .write (acc_write),
    .pr    (perm_r),
    .pw    (perm_w),
    .px    (perm_x),
    .viol  (perm_viol)
  );

  always_comb begin
    hit_n       = win_hit_n;
    viol        = perm_viol;
    deny        = win_hit_n | perm_viol;
    err_capture = ~win_hit_n & perm_viol;
  end

  always_comb begin
    // R10
    capture_implies_deny_chk: assert (!err_capture || deny);
    // R9
    viol_forces_deny_chk: assert (!viol || deny);
    // R3
    invalid_no_capture_chk: assert (rgn_valid || !err_capture);
    // R5
    read_perm_chk: assert (acc_fetch || acc_write || (viol == ~perm_r));
  end
endmodule

// File: tb/rgn_perm_slice_tb_top.sv
module rgn_perm_slice_tb_top;
  localparam int AW = 32;
  typedef struct packed {
    logic hit_n; logic viol; logic deny; logic cap; logic [1:0] kind;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] acc_addr = '0, rgn_lo = '0, rgn_hi = '0;
  logic acc_fetch = 0, acc_write = 0, rgn_valid = 0, perm_r = 0, perm_w = 0, perm_x = 0;
  logic hit_n, viol, deny, err_capture;

  int n_run = 0, n_fail = 0;
  exp_t q[$];
  bit done = 0;

  rgn_perm_slice #(.ADDR_W(AW)) dut_i (
    .acc_addr, .acc_fetch, .acc_write, .rgn_lo, .rgn_hi, .rgn_valid,
    .perm_r, .perm_w, .perm_x, .hit_n, .viol, .deny, .err_capture
  );

  task automatic drive(input logic [AW-1:0] a, input logic f, input logic w,
                       input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                       input logic v, input logic [2:0] rwx);
    exp_t e;
    logic h;
    logic pv;
    @(posedge clk); #1;
    acc_addr = a; acc_fetch = f; acc_write = w; rgn_lo = lo; rgn_hi = hi;
    rgn_valid = v; perm_r = rwx[2]; perm_w = rwx[1]; perm_x = rwx[0];
    h = !(v && a >= lo && a <= hi);
    if (f)      begin pv = !rwx[0]; e.kind = 2'd2; end
    else if (w) begin pv = !rwx[1]; e.kind = 2'd1; end
    else        begin pv = !rwx[2]; e.kind = 2'd0; end
    e.hit_n = h; e.viol = pv; e.deny = h | pv; e.cap = !h & pv;
    q.push_back(e);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      string vt;
      e = q.pop_front();
      vt = (e.kind == 2'd2) ? "R4/R8 fetch viol" :
           (e.kind == 2'd1) ? "R6 write viol" : "R5 read viol";
      chk(rgn_valid ? "R1/R2 hit_n" : "R3 hit_n", hit_n, e.hit_n);
      chk({vt, " (R7, R11)"}, viol, e.viol);
      chk("R9 deny", deny, e.deny);
      chk("R10 err_capture", err_capture, e.cap);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] pos [5];
    pos[0] = 32'h0FF; pos[1] = 32'h100; pos[2] = 32'h180; pos[3] = 32'h1FF; pos[4] = 32'h200;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state vector: all inputs zero, invalid descriptor (R3)
    drive('0, 0, 0, '0, '0, 0, 3'b000);
    for (int v = 0; v < 2; v++)
      for (int k = 0; k < 4; k++)          // k=0 read, 1 write, 2/3 fetch with write 0/1 (R8)
        for (int p = 0; p < 8; p++)        // all permission patterns (R7)
          for (int i = 0; i < 5; i++)      // address positions around bounds (R2)
            drive(pos[i], k >= 2, k[0], 32'h100, 32'h1FF, v[0], p[2:0]);
    // full address range window, extreme addresses (R1, R2)
    drive('0, 0, 0, '0, '1, 1, 3'b100);
    drive('1, 0, 1, '0, '1, 1, 3'b010);
    drive('1, 1, 1, '0, '1, 1, 3'b110);
    // single-address window (R2)
    drive(32'h40, 0, 0, 32'h40, 32'h40, 1, 3'b011);
    drive(32'h41, 0, 0, 32'h40, 32'h40, 1, 3'b100);
    // empty window lo > hi never hits (R1)
    drive(32'h50, 1, 0, 32'h60, 32'h40, 1, 3'b001);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule